// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a cycle-accurate model of a synchronous static RAM. It keeps the data bus fully used when traffic switches between reads and writes. It does this by delaying the write data of each write command by exactly the read latency. A read and a write issued on consecutive cycles then use the bus on consecutive cycles, and no idle slot is needed between them. A mode input picks between a registered output, with two-edge read latency, and a flow-through output, with one-edge read latency. The write-data delay follows the mode.

A command is loaded when advance/load is low. When advance/load is high, the block continues the current command as a burst over the next address of a 2-bit counter. The counter runs in either linear or interleaved order. Each 9-bit byte lane has its own write strobe. Clock enable can freeze the whole block for any number of edges. The bidirectional data bus appears as a data-in port, a data-out port and a drive flag. An asynchronous output enable can turn off the drive flag at any time.

Top module: `nowait_sram`

## Requirements
- R1: A new command is accepted on a rising edge only when clock_en_n is 0, adv_ld is 0, sel1_n is 0, sel2 is 1 and sel3_n is 0. If any one of the three selects is inactive, the edge is a deselect: nothing is read and nothing is written.
- R2: With pipe_mode=1, a read registered at edge n drives its word on dq_out with dq_drive=1 after edge n+1, and not after edge n.
- R3: With pipe_mode=0, a read registered at edge n drives its word on dq_out with dq_drive=1 right after edge n.
- R4: The write data of a write registered at edge n is taken from dq_in at edge n+2 when pipe_mode=1. It is taken at edge n+1 when pipe_mode=0.
- R5: Lane i occupies dq bits [9i+8:9i] and is written only when lane_wr_n[i] is 0. A write with every lane_wr_n bit at 1 changes no stored bit.
- R6: When adv_ld is 1, the previous command continues at the next burst address. The upper address bits stay those of the loaded address. With burst_ilv=0, the low two bits are (loaded + k) mod 4 for step k. After four addresses the sequence restarts at the loaded address.
- R7: With burst_ilv=1, the low two address bits of step k are the loaded low bits XOR k.
- R8: A continue cycle that follows a deselect stays deselected. The select inputs are not looked at on continue cycles.
- R9: An edge with clock_en_n=1 changes no state. A read word already on the bus stays driven with the same value. A write waiting for its data does not sample dq_in at that edge.
- R10: oe_n=1 forces dq_drive to 0 at once, without a clock edge. dq_drive is 0 during the data phase of a write, even with oe_n=0.
- R11: While rst_n is 0, and after reset, dq_drive is 0 until a read completes. Reset leaves stored words unchanged.
- R12: With pipe_mode=1, a read of an address right after a write to the same address returns the newly written lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| clock_en_n | input | 1 | Edge enable, active low; high stalls the block |
| sel1_n | input | 1 | Select, active low |
| sel2 | input | 1 | Select, active high |
| sel3_n | input | 1 | Select, active low |
| wr_n | input | 1 | 0 = write command, 1 = read command |
| adv_ld | input | 1 | 0 = load new command, 1 = continue burst |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| pipe_mode | input | 1 | 1 = registered output, 0 = flow-through |
| burst_ilv | input | 1 | 0 = linear burst, 1 = interleaved burst |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data side of the bus |
| dq_out | output | LANES*LANE_W | Read data side of the bus, zero when not driven |
| dq_drive | output | 1 | Bus driven by the RAM |

## Verification
The hardest case to reach from the ports is a registered-mode read that lands on the same edge at which a late write to the same address finally takes its data. Only a write command, then a read of the same word on the next cycle, then the write data on the cycle after that produces it. The vector table builds this sequence directly and expects the fresh word. A stall that arrives between a write command and its data is just as hard. The bench freezes one edge while a different word sits on dq_in. The value read back afterwards shows which edge actually sampled the data.

// File: rtl/nowait_sram.sv
`timescale 1ns/1ps
module nowait_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 2 ** ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clock_en_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              wr_n,
  input  logic              adv_ld,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pipe_mode,
  input  logic              burst_ilv,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);

  typedef enum logic [1:0] {OP_IDLE, OP_RD, OP_WR} op_e;

  logic [DATA_W-1:0] mem [DEPTH];

  op_e               burst_op, next_op;
  logic [ADDR_W-1:0] base, cur_addr;
  logic [1:0]        step, next_step, low_seed, low_bits;

  logic              c1_rd, c1_wr, c2_wr, out_rd;
  logic [ADDR_W-1:0] c1_addr, c2_addr;
  logic [LANES-1:0]  c1_be, c2_be;
  logic [DATA_W-1:0] out_q, rd_word, fwd_word;

  wire take   = !clock_en_n;
  wire chosen = !sel1_n && sel2 && !sel3_n;
  wire load   = !adv_ld;

  assign next_step = load ? 2'd0 : step + 2'd1;
  assign low_seed  = load ? addr[1:0] : base[1:0];
  assign low_bits  = burst_ilv ? (low_seed ^ next_step) : (low_seed + next_step);
  assign cur_addr  = {load ? addr[ADDR_W-1:2] : base[ADDR_W-1:2], low_bits};

  always_comb begin
    if (!load)       next_op = burst_op;
    else if (!chosen) next_op = OP_IDLE;
    else if (wr_n)    next_op = OP_RD;
    else              next_op = OP_WR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_op <= OP_IDLE;
      step     <= 2'd0;
      base     <= '0;
      c1_rd    <= 1'b0;
      c1_wr    <= 1'b0;
      c1_addr  <= '0;
      c1_be    <= '0;
      c2_wr    <= 1'b0;
      c2_addr  <= '0;
      c2_be    <= '0;
      out_rd   <= 1'b0;
      out_q    <= '0;
    end else if (take) begin
      burst_op <= next_op;
      step     <= next_step;
      if (load) base <= addr;
      c1_rd    <= (next_op == OP_RD);
      c1_wr    <= (next_op == OP_WR);
      c1_addr  <= cur_addr;
      c1_be    <= ~lane_wr_n;
      c2_wr    <= c1_wr && pipe_mode;
      c2_addr  <= c1_addr;
      c2_be    <= c1_be;
      out_rd   <= c1_rd;
      out_q    <= fwd_word;
    end
  end

  wire                wr_fire = pipe_mode ? c2_wr   : c1_wr;
  wire [ADDR_W-1:0]   wr_addr = pipe_mode ? c2_addr : c1_addr;
  wire [LANES-1:0]    wr_lane = pipe_mode ? c2_be   : c1_be;

  always_ff @(posedge clk) begin
    if (take && wr_fire) begin
      for (int l = 0; l < LANES; l++)
        if (wr_lane[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= dq_in[l*LANE_W +: LANE_W];
    end
  end

  assign rd_word = mem[c1_addr];

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    wire hit = pipe_mode && c2_wr && c2_be[g] && (c2_addr == c1_addr);
    assign fwd_word[g*LANE_W +: LANE_W] = hit ? dq_in[g*LANE_W +: LANE_W]
                                              : rd_word[g*LANE_W +: LANE_W];
  end

  assign dq_drive = !oe_n && (pipe_mode ? out_rd : c1_rd);
  assign dq_out   = dq_drive ? (pipe_mode ? out_q : rd_word) : '0;

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clock_en_n && !adv_ld && !(!sel1_n && sel2 && !sel3_n)) |=> (!c1_rd && !c1_wr));

  // R6
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clock_en_n && adv_ld) |=> (step == $past(step) + 2'd1));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clock_en_n |=> ($stable(out_rd) && $stable(out_q) && $stable(c1_rd) &&
                    $stable(c1_wr) && $stable(c2_wr) && $stable(step)));

  // R10
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_drive);

  // R10
  wr_phase_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode ? c2_wr : c1_wr) |-> !dq_drive);

  // R11
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      reset_quiet_chk: assert (!dq_drive);
    end
  end

endmodule

// File: tb/nowait_sram_tb.sv
`timescale 1ns/1ps
module nowait_sram_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b0, s1n = 1'b1, s2 = 1'b0, s3n = 1'b1, we_n = 1'b1, adv = 1'b0;
  logic [1:0]  ben = 2'b11;
  logic [7:0]  ad = 8'h00;
  logic [17:0] din = 18'h0;
  logic pipe = 1'b1, ilv = 1'b0, oe_n = 1'b0;
  logic [17:0] dq_out;
  logic        dq_drive;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  nowait_sram dut_i (
    .clk(clk), .rst_n(rst_n), .clock_en_n(ce_n), .sel1_n(s1n), .sel2(s2), .sel3_n(s3n),
    .wr_n(we_n), .adv_ld(adv), .lane_wr_n(ben), .addr(ad), .pipe_mode(pipe),
    .burst_ilv(ilv), .oe_n(oe_n), .dq_in(din), .dq_out(dq_out), .dq_drive(dq_drive));

  typedef struct packed {
    logic        ce;
    logic        sel;
    logic        w;
    logic        a;
    logic [1:0]  b;
    logic [7:0]  ad;
    logic [17:0] d;
    logic        edrv;
    logic [17:0] edat;
  } vec_t;

  localparam logic [17:0] D0 = 18'h0A5A5, D1 = 18'h15A5A, D2 = 18'h3C0F0, D3 = 18'h00FFF;
  localparam logic [17:0] MRG = 18'h3C1FF;
  localparam logic [17:0] E0 = 18'h11111, E1 = 18'h22222, E2 = 18'h33333, E3 = 18'h04444;
  localparam int NV = 35;

  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,2'b00,8'h10,18'h0,1'b0,18'h0},   // write 0x10
    '{1'b0,1'b1,1'b0,1'b0,2'b00,8'h11,18'h0,1'b0,18'h0},   // write 0x11
    '{1'b0,1'b1,1'b1,1'b0,2'b00,8'h10,D0,1'b0,18'h0},      // R4 data 0x10, R2 read
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,D1,1'b1,D0},         // R2 out D0
    '{1'b0,1'b1,1'b1,1'b0,2'b00,8'h11,18'h0,1'b0,18'h0},
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,18'h0,1'b1,D1},
    '{1'b0,1'b1,1'b0,1'b0,2'b00,8'h20,18'h0,1'b0,18'h0},   // R12 write
    '{1'b0,1'b1,1'b1,1'b0,2'b00,8'h20,18'h0,1'b0,18'h0},   // R12 read same
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,D2,1'b1,D2},         // R12 forwarded
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,18'h0,1'b0,18'h0},
    '{1'b0,1'b1,1'b0,1'b0,2'b10,8'h20,18'h0,1'b0,18'h0},   // R5 lane 0 only
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,18'h0,1'b0,18'h0},
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,D3,1'b0,18'h0},
    '{1'b0,1'b1,1'b1,1'b0,2'b00,8'h20,18'h0,1'b0,18'h0},
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,18'h0,1'b1,MRG},     // R5 merged
    '{1'b0,1'b1,1'b0,1'b0,2'b11,8'h20,18'h0,1'b0,18'h0},   // R5 abort
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,18'h0,1'b0,18'h0},
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,18'h3FFFF,1'b0,18'h0},
    '{1'b0,1'b1,1'b1,1'b0,2'b00,8'h20,18'h0,1'b0,18'h0},
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,18'h0,1'b1,MRG},     // R5 unchanged
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,18'h0,1'b0,18'h0},
    '{1'b0,1'b1,1'b0,1'b0,2'b00,8'h32,18'h0,1'b0,18'h0},   // R6 burst write
    '{1'b0,1'b0,1'b1,1'b1,2'b00,8'h00,18'h0,1'b0,18'h0},   // R8 selects ignored
    '{1'b0,1'b0,1'b1,1'b1,2'b00,8'h00,E0,1'b0,18'h0},      // R10 off in write
    '{1'b0,1'b0,1'b1,1'b1,2'b00,8'h00,E1,1'b0,18'h0},
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,E2,1'b0,18'h0},
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,E3,1'b0,18'h0},
    '{1'b0,1'b1,1'b1,1'b0,2'b00,8'h30,18'h0,1'b0,18'h0},   // R6 burst read
    '{1'b0,1'b0,1'b1,1'b1,2'b11,8'h00,18'h0,1'b1,E2},
    '{1'b0,1'b0,1'b1,1'b1,2'b11,8'h00,18'h0,1'b1,E3},
    '{1'b0,1'b0,1'b1,1'b1,2'b11,8'h00,18'h0,1'b1,E0},
    '{1'b0,1'b0,1'b1,1'b1,2'b11,8'h00,18'h0,1'b1,E1},
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,18'h0,1'b1,E2},      // R6 wrap
    '{1'b0,1'b0,1'b1,1'b1,2'b11,8'h00,18'h0,1'b0,18'h0},   // R8
    '{1'b0,1'b0,1'b1,1'b1,2'b11,8'h00,18'h0,1'b0,18'h0}    // R8
  };

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input logic c, input logic a1, input logic a2, input logic a3,
                     input logic w, input logic a, input logic [1:0] b,
                     input logic [7:0] adr, input logic [17:0] d);
    @(negedge clk);
    ce_n = c; s1n = a1; s2 = a2; s3n = a3; we_n = w; adv = a; ben = b; ad = adr; din = d;
    @(posedge clk);
    #2;
  endtask

  task automatic rd(input logic [7:0] adr);
    run(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, adr, 18'h0);
  endtask
  task automatic wr(input logic [7:0] adr);
    run(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, adr, 18'h0);
  endtask
  task automatic ds(input logic [17:0] d);
    run(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 8'h00, d);
  endtask
  task automatic ct();
    run(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 8'h00, 18'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ce_n = 1'b0; s1n = 1'b1; s2 = 1'b0; s3n = 1'b1; adv = 1'b0; we_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R11 drive in reset", {17'b0, dq_drive}, 18'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R11 drive after reset", {17'b0, dq_drive}, 18'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pipe = 1'b1; ilv = 1'b0; oe_n = 1'b0;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      run(VEC[i].ce, !VEC[i].sel, VEC[i].sel, !VEC[i].sel, VEC[i].w, VEC[i].a,
          VEC[i].b, VEC[i].ad, VEC[i].d);
      chk($sformatf("R2 R4 R5 R6 R8 R10 R12 vector %0d drive", i), {17'b0, dq_drive}, {17'b0, VEC[i].edrv});
      if (VEC[i].edrv) chk($sformatf("R2 R5 R6 R12 vector %0d data", i), dq_out, VEC[i].edat);
    end

    // R1: each select blocks a command
    wr(8'h60); ds(18'h0); ds(18'h2AAAA);
    run(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 8'h60, 18'h0);
    ds(18'h0); ds(18'h15555);
    run(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 8'h60, 18'h0);
    ds(18'h0);
    chk("R1 sel1 inactive no read", {17'b0, dq_drive}, 18'h0);
    run(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 8'h60, 18'h0);
    ds(18'h0);
    chk("R1 sel3 inactive no read", {17'b0, dq_drive}, 18'h0);
    rd(8'h60); ds(18'h0);
    chk("R1 sel2 inactive no write", dq_out, 18'h2AAAA);

    // R9: stall holds a pipelined read on the bus
    rd(8'h30);
    chk("R2 not yet driven", {17'b0, dq_drive}, 18'h0);
    ds(18'h0);
    chk("R2 read data", dq_out, E2);
    run(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 8'h31, 18'h0);
    chk("R9 stall keeps drive", {17'b0, dq_drive}, 18'h1);
    run(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 8'h31, 18'h0);
    chk("R9 stall keeps data", dq_out, E2);
    oe_n = 1'b1; #1;
    chk("R10 oe forces off", {17'b0, dq_drive}, 18'h0);
    oe_n = 1'b0; #1;
    chk("R10 oe released", {17'b0, dq_drive}, 18'h1);
    ds(18'h0);
    chk("R9 stalled command not taken", {17'b0, dq_drive}, 18'h0);

    // R9: stall between write command and its data
    wr(8'h50);
    run(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 8'h00, 18'h3F00F);
    chk("R9 stall during write high-Z", {17'b0, dq_drive}, 18'h0);
    ds(18'h0); ds(18'h0BEEF);
    rd(8'h50); ds(18'h0);
    chk("R9 R4 stalled edge not sampled", dq_out, 18'h0BEEF);

    // R3 R4 flow-through mode
    pipe = 1'b0;
    do_reset();
    wr(8'h40);
    chk("R10 flow write off", {17'b0, dq_drive}, 18'h0);
    ds(18'h1C3C3);
    rd(8'h40);
    chk("R3 flow read same edge", dq_out, 18'h1C3C3);
    ds(18'h0);
    chk("R3 flow drive released", {17'b0, dq_drive}, 18'h0);
    wr(8'h41);
    run(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 8'h41, 18'h2D2D2);
    chk("R4 flow data at n+1", dq_out, 18'h2D2D2);

    // R7 interleaved burst from low bits 01
    ilv = 1'b1;
    rd(8'h31);
    chk("R7 step0", dq_out, E3);
    ct(); chk("R7 step1", dq_out, E2);
    ct(); chk("R7 step2", dq_out, E1);
    ct(); chk("R7 step3", dq_out, E0);
    ct(); chk("R7 R6 wrap", dq_out, E3);
    ds(18'h0);
    chk("R8 burst ended", {17'b0, dq_drive}, 18'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule